// File: doc/BRIEF.md
# Serial Result Transmitter with Selectable Bit Clock

This block sends a 12-bit conversion result out one bit at a time on a serial data line. The bit clock comes from one of two sources, chosen by a level input. In internal mode the block divides the system clock to make its own bit clock. It drives that clock out only while a word is in flight, and each completed conversion starts a word. In external mode the bit clock is an input. A word starts when read/convert rises while chip select is low, or when chip select falls while read/convert is high. The word sent is the result held from the most recent completed conversion.

Each word goes out MSB first. A data bit changes on the falling bit-clock edge and is stable across the following rising edge. A marker pulse lasting one bit-clock period flags the first bit. In external mode the shifter keeps running after the twelfth bit. The values seen on the chaining input at successive rising edges then follow the result, delayed by one word length. This lets several transmitters be chained on a single data line.

The external clock, read/convert and chip select are asynchronous. They pass through a synchronizer and an edge detector clocked by the system clock.

Top module: `serial_result_tx`

## Requirements
- R1: While reset is high, and in the cycle after it, `sdata_o`, `sclk_o` and `sync_o` are all 0.
- R2: In internal mode (`clk_sel_i`=0), a `conv_done_i` pulse starts a word carrying the `result_i` value presented with that pulse. Bits go out MSB first. The MSB appears on the edge that samples the pulse, and each later bit appears on a falling `sclk_o` edge.
- R3: In internal mode, `sclk_o` is low for HALF_DIV cycles and then high for HALF_DIV cycles per bit. It gives exactly 12 high pulses per word and then stays low until the next start.
- R4: In internal mode, `sdata_o` returns to 0 on the twelfth falling edge of `sclk_o`.
- R5: `sync_o` rises together with the MSB and falls on the first falling bit-clock edge, so it lasts one bit-clock period.
- R6: In external mode (`clk_sel_i`=1), `sclk_o` stays 0.
- R7: In external mode, a rising `rdconv_i` while `cs_n_i` is low starts a word. Its MSB and `sync_o` appear within a few system cycles, before the next rising `ext_sclk_i` edge.
- R8: In external mode, a falling `cs_n_i` while `rdconv_i` is high starts a word.
- R9: In external mode, a rising `rdconv_i` while `cs_n_i` is high, or a falling `cs_n_i` while `rdconv_i` is low, starts nothing. `sync_o` and `sdata_o` stay unchanged even while `ext_sclk_i` toggles.
- R10: Each `conv_done_i` pulse stores `result_i`, and an external-mode word sends the stored value. In external mode `conv_done_i` does not start a word.
- R11: In external mode, data advances on each falling `ext_sclk_i` edge. Bit 12+n of the stream equals `tag_i` as sampled at rising edge n+1 of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| result_i | input | 12 | Result of a completed conversion |
| conv_done_i | input | 1 | One-cycle strobe: a conversion has completed |
| clk_sel_i | input | 1 | Bit-clock source: 0 internal, 1 external |
| ext_sclk_i | input | 1 | External bit clock (asynchronous) |
| rdconv_i | input | 1 | Read/convert control (asynchronous) |
| cs_n_i | input | 1 | Chip select, active low (asynchronous) |
| tag_i | input | 1 | Chaining input, shifted out after the result |
| sdata_o | output | 1 | Serial data |
| sclk_o | output | 1 | Internal bit clock, low when idle or in external mode |
| sync_o | output | 1 | First-bit marker |

## Verification
The properties assume that `clk_sel_i` changes only while no word is in flight. They also assume that an internal-mode word is not restarted before its twelfth falling edge. The stimulus respects both: it switches the mode between frames only, and it waits out each internal frame before the next `conv_done_i`. The external clock is held high and low for far longer than the synchronizer latency, and `tag_i` is changed well before each rising edge. As a result, every edge is seen once and tag bits are captured without ambiguity.

// File: rtl/srtx_pkg.sv
package srtx_pkg;
  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } clk_src_e;
endpackage

// File: rtl/srtx_edge_sync.sv
module srtx_edge_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], din[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end
    assign lvl[g]  = chain_q[STAGES-1];
    assign rise[g] = chain_q[STAGES-1] & ~prev_q;
    assign fall[g] = ~chain_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/srtx_clkgen.sv
module srtx_clkgen #(
  parameter int HALF_DIV = 40,
  parameter int BITS     = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic sclk_o,
  output logic rise_p,
  output logic fall_p,
  output logic last_p
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW = $clog2(BITS + 1);

  logic          run_q, lvl_q, expire;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;

  assign expire = run_q && (cnt_q == CW'(HALF_DIV - 1));
  assign rise_p = expire & ~lvl_q;
  assign fall_p = expire & lvl_q;
  assign last_p = fall_p && (bit_q == BW'(BITS - 1));
  assign sclk_o = lvl_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      run_q <= 1'b0;
      lvl_q <= 1'b0;
      cnt_q <= '0;
      bit_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      lvl_q <= 1'b0;
      cnt_q <= '0;
      bit_q <= '0;
    end else if (run_q) begin
      if (expire) begin
        cnt_q <= '0;
        lvl_q <= ~lvl_q;
        if (lvl_q) bit_q <= bit_q + 1'b1;
        if (last_p) run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/srtx_ext_start.sv
module srtx_ext_start (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic rd_lvl,
  input  logic rd_rise,
  input  logic cs_n_lvl,
  input  logic cs_n_fall,
  output logic start_o,
  output logic active_o
);
  logic active_q;

  assign start_o  = enable & ((rd_rise & ~cs_n_lvl) | (cs_n_fall & rd_lvl));
  assign active_o = active_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) active_q <= 1'b0;
    else if (start_o)   active_q <= 1'b1;
  end
endmodule

// File: rtl/srtx_shifter.sv
module srtx_shifter #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  input  logic              rise,
  input  logic              fall,
  input  logic              last,
  input  logic              tag_i,
  output logic              sdata_o,
  output logic              sync_o
);
  logic [DATA_W-1:0] sr_q;
  logic              tag_q, sync_q;

  assign sdata_o = sr_q[DATA_W-1];
  assign sync_o  = sync_q;

  always_ff @(posedge clk) begin
    if (rst) tag_q <= 1'b0;
    else if (rise) tag_q <= tag_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      sync_q <= 1'b0;
    end else if (load) begin
      sr_q   <= word;
      sync_q <= 1'b1;
    end else if (fall) begin
      sync_q <= 1'b0;
      if (last) sr_q <= '0;
      else      sr_q <= {sr_q[DATA_W-2:0], tag_q};
    end
  end
endmodule

// File: rtl/serial_result_tx.sv
module serial_result_tx #(
  parameter int DATA_W      = 12,
  parameter int HALF_DIV    = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] result_i,
  input  logic              conv_done_i,
  input  logic              clk_sel_i,
  input  logic              ext_sclk_i,
  input  logic              rdconv_i,
  input  logic              cs_n_i,
  input  logic              tag_i,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic              sync_o
);
  import srtx_pkg::*;

  localparam int IDX_SCLK = 0;
  localparam int IDX_RD   = 1;
  localparam int IDX_CS   = 2;

  clk_src_e          src;
  logic [2:0]        a_lvl, a_rise, a_fall;
  logic [DATA_W-1:0] result_q, load_word;
  logic              int_start, ext_start, ext_active, is_ext;
  logic              i_rise, i_fall, i_last;
  logic              sh_rise, sh_fall, sh_last, sh_load;

  assign src    = clk_src_e'(clk_sel_i);
  assign is_ext = (src == SRC_EXTERNAL);

  always_ff @(posedge clk) begin
    if (rst) result_q <= '0;
    else if (conv_done_i) result_q <= result_i;
  end

  srtx_edge_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({cs_n_i, rdconv_i, ext_sclk_i}),
    .lvl  (a_lvl),
    .rise (a_rise),
    .fall (a_fall)
  );

  srtx_ext_start u_start (
    .clk       (clk),
    .rst       (rst),
    .enable    (is_ext),
    .rd_lvl    (a_lvl[IDX_RD]),
    .rd_rise   (a_rise[IDX_RD]),
    .cs_n_lvl  (a_lvl[IDX_CS]),
    .cs_n_fall (a_fall[IDX_CS]),
    .start_o   (ext_start),
    .active_o  (ext_active)
  );

  assign int_start = conv_done_i & ~is_ext;

  srtx_clkgen #(.HALF_DIV(HALF_DIV), .BITS(DATA_W)) u_clkgen (
    .clk    (clk),
    .rst    (rst),
    .start  (int_start),
    .abort  (is_ext),
    .sclk_o (sclk_o),
    .rise_p (i_rise),
    .fall_p (i_fall),
    .last_p (i_last)
  );

  always_comb begin
    sh_load   = int_start | ext_start;
    load_word = int_start ? result_i : result_q;
    if (is_ext) begin
      sh_rise = a_rise[IDX_SCLK] & ext_active;
      sh_fall = a_fall[IDX_SCLK] & ext_active;
      sh_last = 1'b0;
    end else begin
      sh_rise = i_rise;
      sh_fall = i_fall;
      sh_last = i_last;
    end
  end

  srtx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (sh_load),
    .word    (load_word),
    .rise    (sh_rise),
    .fall    (sh_fall),
    .last    (sh_last),
    .tag_i   (tag_i),
    .sdata_o (sdata_o),
    .sync_o  (sync_o)
  );
endmodule

// File: rtl/serial_result_tx_chk.sv
module serial_result_tx_chk #(
  parameter int DATA_W = 12
) (
  input logic clk,
  input logic rst,
  input logic clk_sel_i,
  input logic sdata_o,
  input logic sclk_o,
  input logic sync_o
);
  logic [5:0] pulses_q;
  logic       sync_prev_q, sclk_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulses_q    <= '0;
      sync_prev_q <= 1'b0;
      sclk_prev_q <= 1'b0;
    end else begin
      sync_prev_q <= sync_o;
      sclk_prev_q <= sclk_o;
      if (sync_o && !sync_prev_q)                       pulses_q <= '0;
      else if (sclk_o && !sclk_prev_q && pulses_q != 6'h3f) pulses_q <= pulses_q + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!sdata_o && !sclk_o && !sync_o)); // R1

  AST_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    (!clk_sel_i && $rose(sclk_o)) |-> $stable(sdata_o)); // R2

  AST_SHIFT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!clk_sel_i && !$stable(sdata_o) && !$rose(sync_o)) |-> $fell(sclk_o)); // R2

  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    pulses_q <= 6'(DATA_W)); // R3

  AST_SYNC_WITH_LOW_CLK: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> !sclk_o); // R5

  AST_SYNC_ENDS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!clk_sel_i && $fell(sync_o)) |-> $fell(sclk_o)); // R5

  AST_EXT_CLK_SILENT: assert property (@(posedge clk) disable iff (rst)
    clk_sel_i |=> !sclk_o); // R6
endmodule

bind serial_result_tx serial_result_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_sel_i (clk_sel_i),
  .sdata_o   (sdata_o),
  .sclk_o    (sclk_o),
  .sync_o    (sync_o)
);

// File: tb/serial_result_tx_tb_top.sv
module serial_result_tx_tb_top;
  localparam int HALF = 40;
  localparam int EXT_HOLD = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] result_i = '0;
  logic        conv_done_i = 1'b0;
  logic        clk_sel_i = 1'b1;
  logic        ext_sclk_i = 1'b0;
  logic        rdconv_i = 1'b0;
  logic        cs_n_i = 1'b1;
  logic        tag_i = 1'b0;
  logic        sdata_o, sclk_o, sync_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  serial_result_tx #(.DATA_W(12), .HALF_DIV(HALF), .SYNC_STAGES(2)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .result_i    (result_i),
    .conv_done_i (conv_done_i),
    .clk_sel_i   (clk_sel_i),
    .ext_sclk_i  (ext_sclk_i),
    .rdconv_i    (rdconv_i),
    .cs_n_i      (cs_n_i),
    .tag_i       (tag_i),
    .sdata_o     (sdata_o),
    .sclk_o      (sclk_o),
    .sync_o      (sync_o)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic store_result(input logic [11:0] w);
    result_i = w; conv_done_i = 1'b1;
    @(negedge clk);
    conv_done_i = 1'b0;
  endtask

  // one full external clock period; samples sdata before the rising edge
  task automatic ext_bit(input logic exp_bit, input logic exp_sync, input logic tag, input string req);
    check(sdata_o === exp_bit, req, sdata_o, exp_bit);
    check(sync_o === exp_sync, "R5", sync_o, exp_sync);
    tag_i = tag;
    cyc(2);
    ext_sclk_i = 1'b1;
    cyc(EXT_HOLD);
    check(sclk_o === 1'b0, "R6", sclk_o, 0);
    ext_sclk_i = 1'b0;
    cyc(EXT_HOLD);
  endtask

  task automatic t_reset();
    rst = 1'b1; cyc(3);
    check(sdata_o === 0 && sclk_o === 0 && sync_o === 0, "R1", {sdata_o, sclk_o, sync_o}, 0);
    rst = 1'b0; cyc(1);
    check(sdata_o === 0 && sclk_o === 0 && sync_o === 0, "R1", {sdata_o, sclk_o, sync_o}, 0);
  endtask

  task automatic t_no_start();
    clk_sel_i = 1'b1; cs_n_i = 1'b1; rdconv_i = 1'b0; cyc(6);
    rdconv_i = 1'b1; cyc(8);          // rise with chip select high
    check(sync_o === 0, "R9", sync_o, 0);
    rdconv_i = 1'b0; cyc(6);
    cs_n_i = 1'b0; cyc(8);            // select falls while read/convert low
    check(sync_o === 0, "R9", sync_o, 0);
    cs_n_i = 1'b1; cyc(6);
    for (int i = 0; i < 3; i++) ext_bit(1'b0, 1'b0, 1'b1, "R9");
  endtask

  task automatic t_ext_word(input logic [11:0] w, input logic [3:0] tags, input bit by_cs);
    store_result(w);
    cyc(20);
    check(sync_o === 0, "R10", sync_o, 0);  // conv_done in external mode starts nothing
    if (by_cs) begin
      rdconv_i = 1'b1; cs_n_i = 1'b1; cyc(6);
      cs_n_i = 1'b0; cyc(8);
      check(sync_o === 1, "R8", sync_o, 1);
    end else begin
      cs_n_i = 1'b0; rdconv_i = 1'b0; cyc(6);
      rdconv_i = 1'b1; cyc(8);
      check(sync_o === 1, "R7", sync_o, 1);
    end
    for (int i = 0; i < 12; i++)
      ext_bit(w[11-i], (i == 0), tags[i % 4], (i == 0) ? "R10" : "R11");
    for (int n = 0; n < 4; n++)
      ext_bit(tags[n], 1'b0, 1'b0, "R11");
    cs_n_i = 1'b1; rdconv_i = 1'b0; cyc(6);
  endtask

  task automatic t_int_word(input logic [11:0] w);
    int highs;
    clk_sel_i = 1'b0; cyc(4);
    result_i = w; conv_done_i = 1'b1;
    @(negedge clk);
    conv_done_i = 1'b0;
    result_i = ~w;                    // later changes must not affect the word
    check(sdata_o === w[11], "R2", sdata_o, w[11]);
    check(sync_o === 1 && sclk_o === 0, "R5", {sync_o, sclk_o}, 2);
    for (int k = 0; k < 12; k++) begin
      cyc(HALF - 1);
      check(sclk_o === 0, "R3", sclk_o, 0);
      check(sdata_o === w[11-k], "R2", sdata_o, w[11-k]);
      cyc(1);
      check(sclk_o === 1, "R3", sclk_o, 1);
      check(sdata_o === w[11-k], "R2", sdata_o, w[11-k]);
      if (k == 0) begin
        cyc(HALF - 1);
        check(sync_o === 1, "R5", sync_o, 1);
        cyc(1);
        check(sync_o === 0, "R5", sync_o, 0);
      end else begin
        cyc(HALF);
      end
    end
    check(sclk_o === 0, "R3", sclk_o, 0);
    check(sdata_o === 0, "R4", sdata_o, 0);
    highs = 0;
    for (int i = 0; i < 4 * HALF; i++) begin
      @(negedge clk);
      if (sclk_o !== 1'b0 || sdata_o !== 1'b0) highs++;
    end
    check(highs == 0, "R3", highs, 0);
  endtask

  initial begin
    t_reset();
    t_no_start();
    t_ext_word(12'hA5C, 4'b1011, 1'b0);
    t_ext_word(12'h3E1, 4'b0110, 1'b1);
    t_int_word(12'hB4D);
    t_int_word(12'h801);
    clk_sel_i = 1'b1; cyc(4);
    t_ext_word(12'h7F0, 4'b1001, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule